// File: doc/BRIEF.md
# I2C Controller Byte Queues with Receive Watermark

This block holds the two byte queues that sit between an I2C bit engine and its register file. The outbound queue stores 10-bit command words that the register decode pushes and the bit engine consumes. The inbound queue stores 8-bit bytes that the bit engine pushes and the register decode pops, one per read of the receive data register. Each queue is 16 entries deep. The block reports both fill levels zero-based, drives four status flags, raises a receive level event at a software-chosen threshold, and raises a transmit half-empty event. A held control input empties the outbound queue.

Each queue is run by a small fill-class state machine with three states. `Q_EMPTY` holds no entries. `Q_PART` holds between one entry and one short of full. `Q_FULL` holds every slot. The transitions are: `Q_EMPTY -> Q_PART` on an accepted push. `Q_PART -> Q_FULL` on a lone push with one slot left. `Q_PART -> Q_EMPTY` on a lone pop of the last entry. `Q_FULL -> Q_PART` on an accepted pop. A flush sends any state to `Q_EMPTY`. Pushes are accepted only outside `Q_FULL`, and pops only outside `Q_EMPTY`. The empty and full flags come from the state, and the counters are kept separately.

Top module: `i2cq_queues`

## Requirements
- R1: Both queues are 16 entries deep and return entries in the order they were pushed. The outbound queue is 10 bits wide and the inbound queue is 8 bits wide.
- R2: `tx_level` and `rx_level` read as the number of stored entries minus one, and read 0 when the queue is empty.
- R3: `status` carries outbound-full at bit 4, inbound-full at bit 5, inbound-empty at bit 6 and outbound-empty at bit 7. Bits 3 to 0 read 0.
- R4: A push to a full queue is dropped. The level stays at 15 and the stored entries are unchanged.
- R5: A pop from an empty inbound queue leaves `rx_data` at its previous value, and leaves the level and the empty flag as they were.
- R6: A pop from a non-empty inbound queue loads the oldest byte into `rx_data`, visible after that clock edge.
- R7: `rx_mark_evt` is high exactly while the inbound entry count equals `rx_thresh` + 1.
- R8: `tx_half_evt` is high while the outbound entry count is 8 or less, and low at 9 or more.
- R9: While `tx_hold` is high, the outbound queue is empty, outbound-empty is set and pushes are ignored. After release, the queue works normally from empty.
- R10: A push and a pop in the same cycle on a partly filled queue leave the count unchanged.
- R11: `tx_head` shows the oldest outbound word without a pop. After a pop it shows the next word.
- R12: After reset both queues are empty, `status` is 8'hC0, both levels are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_hold | input | 1 | Holds the outbound queue empty while high |
| tx_push | input | 1 | Push `tx_word` into the outbound queue |
| tx_word | input | 10 | Outbound command word |
| tx_pop | input | 1 | Bit engine consumes the oldest outbound word |
| tx_head | output | 10 | Oldest outbound word |
| rx_push | input | 1 | Bit engine pushes `rx_byte` |
| rx_byte | input | 8 | Inbound byte |
| rx_pop | input | 1 | Read strobe of the receive data register |
| rx_data | output | 8 | Last byte popped from the inbound queue |
| rx_thresh | input | 4 | Zero-based inbound threshold |
| tx_level | output | 4 | Outbound level, zero-based |
| rx_level | output | 4 | Inbound level, zero-based |
| status | output | 8 | Queue flags |
| rx_mark_evt | output | 1 | Inbound count reached threshold plus one |
| tx_half_evt | output | 1 | Outbound count at or below half depth |

## Verification
The hardest states to reach from the ports are the two boundary states. One is a full queue that receives one more push. The other is an empty inbound queue that is read again. Both mean walking the count through every level and then adding one more strobe. The stimulus fills each queue with numbered values, pushes a marker value into the full queue, and drains it completely. The marker must never appear, and the data order shows that nothing was overwritten. Because the zero-based level reads the same for an empty queue and a one-entry queue, every check at those levels also inspects the empty flag.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int unsigned QDEPTH   = 16;
    localparam int unsigned TXW      = 10;
    localparam int unsigned RXW      = 8;

    localparam int unsigned ST_TXFULL  = 4;
    localparam int unsigned ST_RXFULL  = 5;
    localparam int unsigned ST_RXEMPTY = 6;
    localparam int unsigned ST_TXEMPTY = 7;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo
    import i2cq_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic [W-1:0]                wdata,
    input  logic                        pop,
    output logic [W-1:0]                head,
    output logic [$clog2(DEPTH):0]      count,
    output logic                        full,
    output logic                        empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, cnt_nxt;
    qstate_e       st, st_nxt;
    logic          can_push, can_pop;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && !flush && can_push;
    assign pop_ok  = pop  && !flush && can_pop;

    always_comb begin
        cnt_nxt = cnt;
        if (push_ok && !pop_ok) cnt_nxt = cnt + 1'b1;
        if (pop_ok && !push_ok) cnt_nxt = cnt - 1'b1;
    end

    // next-state process
    always_comb begin
        st_nxt = st;
        unique case (st)
            Q_EMPTY: if (push_ok) st_nxt = Q_PART;
            Q_PART: begin
                if (push_ok && !pop_ok && cnt == CW'(DEPTH - 1)) st_nxt = Q_FULL;
                if (pop_ok && !push_ok && cnt == CW'(1))         st_nxt = Q_EMPTY;
            end
            Q_FULL:  if (pop_ok && !push_ok) st_nxt = Q_PART;
            default: st_nxt = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= Q_EMPTY;
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            st     <= Q_EMPTY;
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (push_ok) wr_ptr <= ptr_step(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // output process
    always_comb begin
        unique case (st)
            Q_EMPTY: begin empty = 1'b1; full = 1'b0; can_push = 1'b1; can_pop = 1'b0; end
            Q_PART:  begin empty = 1'b0; full = 1'b0; can_push = 1'b1; can_pop = 1'b1; end
            Q_FULL:  begin empty = 1'b0; full = 1'b1; can_push = 1'b0; can_pop = 1'b1; end
            default: begin empty = 1'b1; full = 1'b0; can_push = 1'b0; can_pop = 1'b0; end
        endcase
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;

    AST_STATE_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (cnt == '0)) && (full == (cnt == CW'(DEPTH)))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R1
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (cnt == CW'(DEPTH))); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0 && empty)); // R9
    AST_BOTH_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && push && pop && !flush) |=> $stable(cnt)); // R10
endmodule

// File: rtl/i2cq_report.sv
module i2cq_report
    import i2cq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic [$clog2(DEPTH):0]   tx_count,
    input  logic [$clog2(DEPTH):0]   rx_count,
    input  logic [$clog2(DEPTH)-1:0] thresh,
    output logic [$clog2(DEPTH)-1:0] tx_lvl,
    output logic [$clog2(DEPTH)-1:0] rx_lvl,
    output logic                     rx_evt,
    output logic                     tx_half
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned CW   = AW + 1;
    localparam int unsigned HALF = DEPTH / 2;

    function automatic logic [AW-1:0] zero_based(input logic [CW-1:0] c);
        logic [CW-1:0] m;
        m = (c == '0) ? '0 : c - 1'b1;
        return m[AW-1:0];
    endfunction

    assign tx_lvl  = zero_based(tx_count);
    assign rx_lvl  = zero_based(rx_count);
    assign rx_evt  = (rx_count == ({1'b0, thresh} + CW'(1)));
    assign tx_half = (tx_count <= CW'(HALF));
endmodule

// File: rtl/i2cq_queues.sv
module i2cq_queues
    import i2cq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_hold,
    input  logic            tx_push,
    input  logic [TXW-1:0]  tx_word,
    input  logic            tx_pop,
    output logic [TXW-1:0]  tx_head,
    input  logic            rx_push,
    input  logic [RXW-1:0]  rx_byte,
    input  logic            rx_pop,
    output logic [RXW-1:0]  rx_data,
    input  logic [$clog2(QDEPTH)-1:0] rx_thresh,
    output logic [$clog2(QDEPTH)-1:0] tx_level,
    output logic [$clog2(QDEPTH)-1:0] rx_level,
    output logic [7:0]      status,
    output logic            rx_mark_evt,
    output logic            tx_half_evt
);
    localparam int unsigned AW = $clog2(QDEPTH);
    localparam int unsigned CW = AW + 1;

    logic [CW-1:0]  tx_cnt, rx_cnt;
    logic           tx_full, tx_empty, rx_full, rx_empty;
    logic [RXW-1:0] rx_head;

    i2cq_fifo #(.W(TXW), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_hold),
        .push(tx_push), .wdata(tx_word), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    i2cq_fifo #(.W(RXW), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    i2cq_report #(.DEPTH(QDEPTH)) u_rep (
        .tx_count(tx_cnt), .rx_count(rx_cnt), .thresh(rx_thresh),
        .tx_lvl(tx_level), .rx_lvl(rx_level),
        .rx_evt(rx_mark_evt), .tx_half(tx_half_evt)
    );

    // receive data register: updated only by a pop that finds data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rx_data <= '0;
        else if (rx_pop && !rx_empty) rx_data <= rx_head;
    end

    always_comb begin
        status             = '0;
        status[ST_TXFULL]  = tx_full;
        status[ST_RXFULL]  = rx_full;
        status[ST_RXEMPTY] = rx_empty;
        status[ST_TXEMPTY] = tx_empty;
    end

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && rx_pop && !rx_push) |=> $stable(rx_data)); // R5
    AST_MARK_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mark_evt |-> !rx_empty); // R7
    AST_HOLD_GIVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |=> (status[ST_TXEMPTY] && tx_half_evt)); // R9
endmodule

// File: tb/i2cq_queues_test.sv
module i2cq_queues_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_hold = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [9:0] tx_word = '0;
    logic [9:0] tx_head;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rx_data;
    logic [3:0] rx_thresh = 4'd2;
    logic [3:0] tx_level, rx_level;
    logic [7:0] status;
    logic       rx_mark_evt, tx_half_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cq_queues uut (
        .clk(clk), .rst_n(rst_n), .tx_hold(tx_hold),
        .tx_push(tx_push), .tx_word(tx_word), .tx_pop(tx_pop), .tx_head(tx_head),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_thresh(rx_thresh), .tx_level(tx_level), .rx_level(rx_level),
        .status(status), .rx_mark_evt(rx_mark_evt), .tx_half_evt(tx_half_evt)
    );

    // control {tx_push, tx_pop, rx_push, rx_pop}, tx word, rx byte,
    // expected tx level, rx level, status, rx_data, mark event
    localparam logic [46:0] TBL [0:7] = '{
        {4'b1000, 10'h155, 8'h00, 4'd0, 4'd0, 8'h40, 8'h00, 1'b0},
        {4'b0010, 10'h000, 8'hA1, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0},
        {4'b1010, 10'h2AA, 8'hB2, 4'd1, 4'd1, 8'h00, 8'h00, 1'b0},
        {4'b0010, 10'h000, 8'hC3, 4'd1, 4'd2, 8'h00, 8'h00, 1'b1},
        {4'b0001, 10'h000, 8'h00, 4'd1, 4'd1, 8'h00, 8'hA1, 1'b0},
        {4'b0100, 10'h000, 8'h00, 4'd0, 4'd1, 8'h00, 8'hA1, 1'b0},
        {4'b0011, 10'h000, 8'hD4, 4'd0, 4'd1, 8'h00, 8'hB2, 1'b0},
        {4'b0100, 10'h000, 8'h00, 4'd0, 4'd1, 8'h80, 8'hB2, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // inputs are set after a falling edge; one rising edge passes; sample at the next falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [9:0] w);
        tx_push = 1'b1; tx_word = w; cyc();
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b; cyc();
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 status", status, 8'hC0);
        check("R12 tx_level", tx_level, 0);
        check("R12 rx_level", rx_level, 0);
        check("R12 rx_data", rx_data, 0);
        check("R8 half at empty", tx_half_evt, 1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic [46:0] v;
            v = TBL[i];
            tx_push = v[46]; tx_pop = v[45]; rx_push = v[44]; rx_pop = v[43];
            tx_word = v[42:33]; rx_byte = v[32:25];
            cyc();
            check("R2 tx_level", tx_level, v[24:21]);
            check("R2 rx_level", rx_level, v[20:17]);
            check("R3 status", status, v[16:9]);
            check("R6 rx_data", rx_data, v[8:1]);
            check("R7 mark", rx_mark_evt, v[0]);
            if (i == 5) check("R11 head after pop", tx_head, 10'h2AA);
            if (i == 6) check("R10 same-cycle push/pop", rx_level, 1);
        end

        // drain inbound: C3 then D4, then read empty
        pop_rx();
        check("R6 data C3", rx_data, 8'hC3);
        pop_rx();
        check("R6 data D4", rx_data, 8'hD4);
        check("R3 rx empty", status[6], 1);
        pop_rx();
        check("R5 empty read holds", rx_data, 8'hD4);
        check("R5 level", rx_level, 0);
        check("R5 still empty", status[6], 1);

        // outbound fill with half-empty boundary and overflow drop
        for (int i = 0; i < 16; i++) begin
            push_tx(10'h100 + 10'(i));
            if (i == 0) check("R11 head peek", tx_head, 10'h100);
            if (i == 7) check("R8 half at 8", tx_half_evt, 1);
            if (i == 8) check("R8 not half at 9", tx_half_evt, 0);
        end
        check("R1 tx full flag", status[4], 1);
        check("R2 tx level full", tx_level, 15);
        check("R3 low bits zero", status[3:0], 0);
        push_tx(10'h3FF);
        check("R4 tx drop level", tx_level, 15);
        for (int i = 0; i < 16; i++) begin
            check("R1 tx order", tx_head, 10'h100 + 10'(i));
            tx_pop = 1'b1; cyc();
        end
        check("R4 tx drained", status[7], 1);

        // outbound hold
        push_tx(10'h011); push_tx(10'h022); push_tx(10'h033);
        check("R2 tx three", tx_level, 2);
        tx_hold = 1'b1; cyc();
        check("R9 hold empties", status[7], 1);
        check("R9 hold level", tx_level, 0);
        push_tx(10'h044);
        check("R9 push ignored", status[7], 1);
        tx_hold = 1'b0;
        push_tx(10'h077);
        check("R9 after release head", tx_head, 10'h077);
        check("R9 after release not empty", status[7], 0);
        tx_pop = 1'b1; cyc();

        // inbound fill to threshold 15 and overflow
        rx_thresh = 4'd15;
        for (int i = 0; i < 16; i++) begin
            push_rx(8'h30 + 8'(i));
            if (i == 14) check("R7 below mark", rx_mark_evt, 0);
        end
        check("R7 mark at 16", rx_mark_evt, 1);
        check("R3 rx full", status[5], 1);
        push_rx(8'hEE);
        check("R4 rx drop level", rx_level, 15);
        for (int i = 0; i < 16; i++) begin
            pop_rx();
            check("R1 rx order", rx_data, 8'h30 + 8'(i));
        end
        check("R2 rx empty level", rx_level, 0);
        check("R3 rx empty flag", status[6], 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule